// File: doc/BRIEF.md
# Receive Circular Buffer Writer

This block sits between a receive character assembler and main memory. Each completed character arrives with its line number and a break flag. The block turns it into a tagged 16-bit entry and appends it to a 64-slot ring held in memory. The block holds only the write index. Whether a slot is occupied is carried by a valid bit inside the entry itself. Software drains the ring by clearing that bit.

Before every append, the block reads the slot it is about to fill. If software has not yet emptied that slot, the character is dropped, an overrun flag is raised and the index does not move. Otherwise the block writes the entry, advances the index with wrap-around, and raises a done flag. An interrupt request follows the done flag while the interrupt enable is set. Both flags are cleared by write-one pulses.

The sequencer has three states. **IDLE** accepts a character and moves to **READ**. **READ** holds a read request until acknowledged, then goes to **WRITE** when the slot is free, or back to **IDLE** when the slot is taken (the overrun path). **WRITE** holds a write request until acknowledged, then returns to **IDLE**.

Top module: `rxbuf_writer`

## Requirements
- R1: After reset the write index is 0, so the first entry goes to slot 0. `rx_done`, `rx_ovr`, `rx_irq` and `mem_req` are 0, and `in_ready` is 1.
- R2: Slot k lives at byte address `{tbl_base, 1'b1, k[5:0], 1'b0}`. This is a buffer at offset 0x80 inside a 256-byte page whose upper byte is `tbl_base`.
- R3: An entry has this layout: bit 15 is valid (written as 1), bit 14 is the break flag, bit 13 is parity, bits 12:9 are the line number, bit 8 is 0 and bits 7:0 are the character. The parity bit is 1 when the justified character holds an odd number of ones.
- R4: `in_chr` arrives left-aligned. The character length is given by `in_len` as 0=5, 1=6, 2=7 or 3=8 bits. The stored character is `in_chr >> (3 - in_len)`, right-justified with zeros above it.
- R5: Every write is preceded by a read of the same slot. The write request starts in the cycle right after that read is acknowledged.
- R6: If the slot read back has bit 15 set, no write is issued and `rx_ovr` is set. The write index stays where it was, so the next stored character goes to that same slot.
- R7: After slot 63 the write index wraps to slot 0.
- R8: An acknowledged write sets `rx_done`. `rx_irq` is high exactly when `rx_done` and `irq_en` are both 1.
- R9: A `clr_done` or `clr_ovr` pulse clears its flag on the next edge. If a flag's set event falls in the same cycle as its clear pulse, the flag ends up set.
- R10: `in_ready` is 0 whenever a request is outstanding. Address, direction and write data hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character offered by assembler |
| in_ready | output | 1 | Block can accept a character |
| in_chr | input | 8 | Received bits, left-aligned |
| in_len | input | 2 | Character length code |
| in_brk | input | 1 | Break detected on the line |
| in_line | input | 4 | Line number |
| tbl_base | input | 8 | Upper address byte of the table page |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Entry to write |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| irq_en | input | 1 | Receive interrupt enable |
| clr_done | input | 1 | Write-one clear of done |
| clr_ovr | input | 1 | Write-one clear of overrun |
| rx_done | output | 1 | Character stored |
| rx_ovr | output | 1 | Character dropped, ring full |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The two functions that can coincide are a flag being set by the sequencer and the same flag being cleared by software in one cycle. For done, the set event is the write acknowledge. For overrun, it is a read acknowledge that returns a taken slot. The bench's memory model provokes each collision on demand: when it grants that specific acknowledge, it also pulses the matching clear. The flag must then still read 1 afterwards. Separate, uncontested clear pulses must bring it to 0.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int CHR_W  = 8;
    localparam int LINE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } rxb_state_e;

    typedef struct packed {
        logic              valid;
        logic              brk;
        logic              par;
        logic [LINE_W-1:0] line;
        logic              spare;
        logic [CHR_W-1:0]  chr;
    } rxb_entry_t;
endpackage

// File: rtl/rxb_format.sv
module rxb_format
    import rxb_pkg::*;
(
    input  logic [CHR_W-1:0]  raw_chr,
    input  logic [1:0]        len_code,
    input  logic              brk,
    input  logic [LINE_W-1:0] line,
    output rxb_entry_t        entry
);
    logic [1:0]       drop_bits;
    logic [CHR_W-1:0] justified;

    always_comb begin
        drop_bits   = 2'd3 - len_code;
        justified   = raw_chr >> drop_bits;
        entry.valid = 1'b1;
        entry.brk   = brk;
        entry.par   = ^justified;
        entry.line  = line;
        entry.spare = 1'b0;
        entry.chr   = justified;
    end
endmodule

// File: rtl/rxb_seq.sv
module rxb_seq
    import rxb_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int BASE_W = 8,
    localparam int ADDR_W = BASE_W + IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  rxb_entry_t        entry_in,
    input  logic [BASE_W-1:0] base_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              slot_taken,
    output logic              set_done,
    output logic              set_ovr
);
    localparam logic [IDX_W-1:0] IDX_LAST = '1;

    rxb_state_e        state, nxt;
    logic [IDX_W-1:0]  wr_idx;
    rxb_entry_t        entry_q;
    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_idx  <= '0;
            entry_q <= '0;
            base_q  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && in_valid) begin
                entry_q <= entry_in;
                base_q  <= base_in;
            end
            if (state == ST_WRITE && mem_ack)
                wr_idx <= (wr_idx == IDX_LAST) ? '0 : wr_idx + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (in_valid) nxt = ST_READ;
            ST_READ:  if (mem_ack)  nxt = slot_taken ? ST_IDLE : ST_WRITE;
            ST_WRITE: if (mem_ack)  nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        set_done  = 1'b0;
        set_ovr   = 1'b0;
        mem_addr  = {base_q, 1'b1, wr_idx, 1'b0};
        mem_wdata = entry_q;
        unique case (state)
            ST_IDLE:  in_ready = 1'b1;
            ST_READ: begin
                mem_req = 1'b1;
                set_ovr = mem_ack && slot_taken;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                set_done = mem_ack;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxb_flags.sv
module rxb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_ovr,
    input  logic clr_done,
    input  logic clr_ovr,
    input  logic irq_en,
    output logic done,
    output logic ovr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (set_done)      done <= 1'b1;
            else if (clr_done) done <= 1'b0;
            if (set_ovr)       ovr  <= 1'b1;
            else if (clr_ovr)  ovr  <= 1'b0;
        end
    end

    assign irq = done & irq_en;
endmodule

// File: rtl/rxbuf_writer.sv
module rxbuf_writer
    import rxb_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int BASE_W = 8,
    localparam int ADDR_W = BASE_W + IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CHR_W-1:0]  in_chr,
    input  logic [1:0]        in_len,
    input  logic              in_brk,
    input  logic [LINE_W-1:0] in_line,
    input  logic [BASE_W-1:0] tbl_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic              irq_en,
    input  logic              clr_done,
    input  logic              clr_ovr,
    output logic              rx_done,
    output logic              rx_ovr,
    output logic              rx_irq
);
    rxb_entry_t new_entry;
    rxb_entry_t rd_word;
    logic       set_done, set_ovr;
    logic       rd_unused;

    assign rd_word   = mem_rdata;
    assign rd_unused = ^{rd_word.brk, rd_word.par, rd_word.line, rd_word.spare, rd_word.chr};

    rxb_format u_fmt (
        .raw_chr  (in_chr),
        .len_code (in_len),
        .brk      (in_brk),
        .line     (in_line),
        .entry    (new_entry)
    );

    rxb_seq #(.IDX_W(IDX_W), .BASE_W(BASE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .entry_in   (new_entry),
        .base_in    (tbl_base),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .slot_taken (rd_word.valid),
        .set_done   (set_done),
        .set_ovr    (set_ovr)
    );

    rxb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (set_done),
        .set_ovr  (set_ovr),
        .clr_done (clr_done),
        .clr_ovr  (clr_ovr),
        .irq_en   (irq_en),
        .done     (rx_done),
        .ovr      (rx_ovr),
        .irq      (rx_irq)
    );
endmodule

// File: rtl/rxbuf_writer_chk.sv
module rxbuf_writer_chk #(
    parameter int IDX_W  = 6,
    parameter int BASE_W = 8,
    localparam int ADDR_W = BASE_W + IDX_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [BASE_W-1:0] tbl_base,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              mem_ack,
    input logic              rd_valid_bit,
    input logic              irq_en,
    input logic              clr_done,
    input logic              rx_done,
    input logic              rx_ovr,
    input logic              rx_irq
);
    logic wr_ack, rd_ack;
    assign wr_ack = mem_req && mem_we && mem_ack;
    assign rd_ack = mem_req && !mem_we && mem_ack;

    // R2
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ADDR_W-1:IDX_W+2] == tbl_base) && mem_addr[IDX_W+1] && !mem_addr[0]);

    // R5
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req && mem_we) |-> $past(rd_ack));

    // R6
    overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_valid_bit) |=> (rx_ovr && !mem_req));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> irq_en);

    // R9
    done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> rx_done);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !wr_ack) |=> !rx_done);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !in_ready);
endmodule

bind rxbuf_writer rxbuf_writer_chk #(.IDX_W(IDX_W), .BASE_W(BASE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .tbl_base     (tbl_base),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .rd_valid_bit (mem_rdata[15]),
    .irq_en       (irq_en),
    .clr_done     (clr_done),
    .rx_done      (rx_done),
    .rx_ovr       (rx_ovr),
    .rx_irq       (rx_irq)
);

// File: tb/rxbuf_writer_bench.sv
module rxbuf_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_chr = '0;
    logic [1:0]  in_len = '0;
    logic        in_brk = 1'b0;
    logic [3:0]  in_line = '0;
    logic [7:0]  tbl_base = 8'h3A;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        irq_en = 1'b0;
    logic        clr_done = 1'b0, clr_ovr = 1'b0;
    logic        rx_done, rx_ovr, rx_irq;

    int checks = 0, errors = 0;
    logic [15:0] mem [0:63];
    int  wr_count = 0, last_wr_idx = -1, last_rd_idx = -1, seq_bad = 0, addr_bad = 0;
    bit  last_was_read = 0;
    bit  pend_cd = 0, pend_co = 0, collide_done = 0, collide_ovr = 0;
    int  lat = 0;
    int  exp_idx = 0, rd_idx = 0, pending = 0;
    bit  exp_done = 0, exp_ovr = 0;
    int unsigned seed_v;

    always #5 clk = ~clk;

    rxbuf_writer u_rxbuf_writer (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] mk_entry(logic [7:0] c, logic [1:0] len, logic b, logic [3:0] ln);
        logic [7:0] j;
        j = c >> (2'd3 - len);
        return {1'b1, b, ^j, ln, 1'b0, j};
    endfunction

    // memory model and software clear driver
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            clr_done = pend_cd;
            clr_ovr  = pend_co;
            pend_cd  = 0;
            pend_co  = 0;
            mem_ack  = 1'b0;
            if (rst_n && mem_req) begin
                if (lat == 0) begin
                    int idx;
                    idx = int'(mem_addr[6:1]);
                    if (mem_addr[15:8] != tbl_base || !mem_addr[7] || mem_addr[0]) addr_bad++;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        if (!last_was_read || last_rd_idx != idx) seq_bad++;
                        mem[idx] = mem_wdata;
                        wr_count++;
                        last_wr_idx = idx;
                        last_was_read = 0;
                        if (collide_done) clr_done = 1'b1;
                    end else begin
                        mem_rdata = mem[idx];
                        last_rd_idx = idx;
                        last_was_read = 1;
                        if (collide_ovr && mem[idx][15]) clr_ovr = 1'b1;
                    end
                    lat = int'($urandom % 3);
                end else lat--;
            end
        end
    end

    task automatic sw_clear(input bit d, input bit o);
        @(posedge clk);
        pend_cd = d;
        pend_co = o;
        @(negedge clk);
        @(negedge clk);
        if (d) exp_done = 0;
        if (o) exp_ovr = 0;
    endtask

    task automatic consume_one();
        mem[rd_idx][15] = 1'b0;
        rd_idx = (rd_idx + 1) % 64;
        pending--;
    endtask

    task automatic send(input logic [7:0] c, input logic [1:0] len, input logic b, input logic [3:0] ln);
        logic [15:0] slot_before, want;
        int wc_before;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        slot_before = mem[exp_idx];
        wc_before = wr_count;
        want = mk_entry(c, len, b, ln);
        in_valid = 1'b1; in_chr = c; in_len = len; in_brk = b; in_line = ln;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R10 busy not ready", in_ready, 0);
        while (!in_ready) @(negedge clk);
        if (slot_before[15]) begin
            exp_ovr = 1;
            chk(wr_count == wc_before, "R6 no write on taken slot", wr_count, wc_before);
            chk(mem[exp_idx] == slot_before, "R6 slot untouched", mem[exp_idx], slot_before);
        end else begin
            exp_done = 1;
            chk(wr_count == wc_before + 1, "R5 one write", wr_count, wc_before + 1);
            chk(last_wr_idx == exp_idx, "R7 write index", last_wr_idx, exp_idx);
            chk(mem[exp_idx] == want, "R3 R4 entry", mem[exp_idx], want);
            exp_idx = (exp_idx + 1) % 64;
            pending++;
        end
        chk(rx_done == exp_done, "R8 done", rx_done, exp_done);
        chk(rx_ovr == exp_ovr, "R6 overrun flag", rx_ovr, exp_ovr);
        chk(rx_irq == (exp_done && irq_en), "R8 irq", rx_irq, exp_done && irq_en);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        seed_v = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rx_done && !rx_ovr && !rx_irq, "R1 flags after reset", {rx_done, rx_ovr, rx_irq}, 0);
        chk(!mem_req && in_ready, "R1 idle after reset", {mem_req, in_ready}, 1);

        // R1 first slot, R4 every length code, R3 break/line fields
        irq_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            send(8'hB7 ^ 8'(k * 37), 2'(k), k[0], 4'(15 - k));
            consume_one();
        end
        chk(last_wr_idx == 7, "R1 index started at 0", last_wr_idx, 7);

        // R8 interrupt gating
        irq_en = 1'b0;
        @(negedge clk);
        chk(!rx_irq && rx_done, "R8 irq masked", rx_irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(rx_irq, "R8 irq enabled", rx_irq, 1);

        // R9 plain clear of done
        sw_clear(1, 0);
        chk(!rx_done, "R9 done cleared", rx_done, 0);

        // random traffic with random draining
        for (int n = 0; n < 300; n++) begin
            while (pending > 0 && ($urandom % 4) != 0) consume_one();
            if (($urandom % 16) == 0) irq_en = ~irq_en;
            if (($urandom % 10) == 0) sw_clear(1'($urandom), 1'($urandom));
            send(8'($urandom), 2'($urandom), 1'($urandom), 4'($urandom));
        end

        // fill the ring, then overrun (R6), then R7 wrap continuity
        while (pending > 0) consume_one();
        sw_clear(1, 1);
        chk(!rx_ovr && !rx_done, "R9 both cleared", {rx_done, rx_ovr}, 0);
        for (int k = 0; k < 64; k++) send(8'(k), 2'd3, 1'b0, 4'(k));
        chk(pending == 64, "R7 full ring stored", pending, 64);
        send(8'hFF, 2'd3, 1'b1, 4'd9);
        chk(rx_ovr, "R6 overrun on full ring", rx_ovr, 1);
        consume_one();
        send(8'hC3, 2'd1, 1'b0, 4'd2);
        chk(last_wr_idx == (exp_idx + 63) % 64, "R6 index held after drop", last_wr_idx, (exp_idx + 63) % 64);

        // R9 set wins: overrun set coincident with clear
        collide_ovr = 1;
        send(8'h11, 2'd2, 1'b0, 4'd1);
        collide_ovr = 0;
        chk(rx_ovr, "R9 overrun set beats clear", rx_ovr, 1);
        sw_clear(0, 1);
        chk(!rx_ovr, "R9 overrun cleared", rx_ovr, 0);

        // R9 set wins: done set coincident with clear
        consume_one();
        collide_done = 1;
        send(8'h5A, 2'd0, 1'b1, 4'd6);
        collide_done = 0;
        chk(rx_done, "R9 done set beats clear", rx_done, 1);

        chk(seq_bad == 0, "R5 read precedes write", seq_bad, 0);
        chk(addr_bad == 0, "R2 address window", addr_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule